// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external 8192-word by 8-bit asynchronous static RAM. Each accepted request is a single-word read or write. The controller sequences the RAM's two chip enables (one active low, one active high), its output enable and its write enable. It drives a 13-bit address and splits the bidirectional data bus into an output value, an output-enable and an input value.

Every phase lasts a whole number of clock cycles. Each phase length is the ceiling of the relevant RAM timing limit divided by the `CLK_PERIOD_NS` parameter, so the minimum access, pulse, setup and cycle times hold at any clock rate. Read data is captured on the last cycle of the access phase and returned as a one-cycle response pulse. A write that follows a read waits out the RAM's high-impedance delay before the controller drives the data bus. A new request can be accepted in the cycle right after the previous operation ends.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `sram_ce_n`=1, `sram_ce`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0 and `rsp_valid`=0.
- R2: Whenever `sram_oe_n` is 0, the chip is selected (`sram_ce_n`=0, `sram_ce`=1), `sram_we_n` is 1 and `sram_dq_oe` is 0.
- R3: Whenever `sram_we_n` is 0, the chip is selected, `sram_oe_n` is 1 and `sram_dq_oe` is 1.
- R4: For a read accepted on clock edge A, `rsp_valid` is 1 for exactly the one cycle that starts at edge A+RD. RD = ceil(max(80 ns access, 80 ns cycle, 40 ns output-enable) / `CLK_PERIOD_NS`).
- R5: `rsp_rdata` equals the last byte written to the same 13-bit address (0 if the address was never written), over the full range 0 to 8191.
- R6: The write-enable low pulse lasts at least 60 ns. Write data is driven and unchanged for at least 40 ns before write enable rises and does not change on that edge. Address and chip select are stable for at least 70 ns before that edge.
- R7: The address changes only while the chip is deselected, and each address is held for at least 80 ns.
- R8: `sram_dq_oe` is 0 whenever the RAM drives the bus. It rises no sooner than 30 ns after the RAM's read enable ends.
- R9: `req_ready` is 1 only while the chip is deselected, and it falls in the cycle after an acceptance. In the cycle of a read response `req_ready` is 1, so the next request can be accepted on the following edge.
- R10: The write-enable low pulse lasts exactly ceil(max(60, 40) / `CLK_PERIOD_NS`) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 13 | RAM address |
| sram_ce_n | output | 1 | RAM enable, active low |
| sram_ce | output | 1 | RAM enable, active high |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Data toward RAM |
| sram_dq_oe | output | 1 | Controller drives data bus |
| sram_dq_in | input | 8 | Data from RAM |

## Verification
A read's response pulse and the acceptance of the next request land in neighbouring cycles: the response cycle is also a ready cycle. The bench provokes this by issuing requests back to back, including a read followed at once by a write to the same address. A cycle-by-cycle model checks that the response appears exactly RD cycles after acceptance, that `req_ready` is high in that same cycle, and that the byte belongs to the older read, not to the write queued behind it. A behavioural RAM model in the bench checks the strobe timing and flags any data-bus contention during the turnaround.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } asram_state_e;

  // ceiling of a time in ns divided by the clock period
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period);
    if (period == 0) return ns;
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max_u(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, clamped at zero
  function automatic int unsigned sat_sub(input int unsigned a,
                                          input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/asram_bus_turn.sv
module asram_bus_turn #(
  parameter int          CNT_W  = 4,
  parameter int unsigned HZ_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_release,
  output logic bus_quiet
);

  logic [CNT_W-1:0] hz_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hz_left <= '0;
    end else if (rd_release) begin
      hz_left <= CNT_W'(HZ_CYC);
    end else if (hz_left != '0) begin
      hz_left <= hz_left - CNT_W'(1);
    end
  end

  // one cycle of slack is absorbed by the write setup phase
  assign bus_quiet = (hz_left <= CNT_W'(1));

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_data <= din;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int          ADDR_W        = 13,
  parameter int          DATA_W        = 8,
  parameter int unsigned T_AA_NS       = 80,
  parameter int unsigned T_RC_NS       = 80,
  parameter int unsigned T_OE_NS       = 40,
  parameter int unsigned T_HZ_NS       = 30,
  parameter int unsigned T_WC_NS       = 80,
  parameter int unsigned T_CW_NS       = 70,
  parameter int unsigned T_WP_NS       = 60,
  parameter int unsigned T_DW_NS       = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned RD_CYC  = max_u(max_u(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                                ns_to_cycles(T_RC_NS, CLK_PERIOD_NS)),
                                          ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned WP_CYC  = max_u(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_DW_NS, CLK_PERIOD_NS));
  localparam int unsigned SU_CYC  = max_u(1, sat_sub(ns_to_cycles(T_CW_NS, CLK_PERIOD_NS),
                                                     WP_CYC));
  localparam int unsigned REC_CYC = max_u(1, sat_sub(ns_to_cycles(T_WC_NS, CLK_PERIOD_NS),
                                                     SU_CYC + WP_CYC));
  localparam int unsigned HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WP_CYC),
                                          max_u(max_u(SU_CYC, REC_CYC), HZ_CYC));
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  // R10: every phase must span at least one clock
  if (RD_CYC < 1 || WP_CYC < 1 || SU_CYC < 1 || REC_CYC < 1) begin : g_bad_phase
    $error("asram_ctrl: a computed phase length is below one cycle");
  end

  asram_state_e state, state_d;

  // named internal events
  logic             accept;
  logic             rd_done;
  logic             we_fall;
  logic             we_rise;
  logic             wr_done;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;
  logic             bus_quiet;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ce_act;
  logic              oe_act;
  logic              we_act;
  logic              dq_oe_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  asram_bus_turn #(.CNT_W(CNT_W), .HZ_CYC(HZ_CYC)) u_turn (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_release (rd_done),
    .bus_quiet  (bus_quiet)
  );

  asram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_done),
    .din       (sram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata)
  );

  always_comb begin
    state_d = state;
    t_load  = 1'b0;
    t_val   = '0;
    rd_done = 1'b0;
    we_fall = 1'b0;
    we_rise = 1'b0;
    wr_done = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (!req_write) begin
            state_d = ST_READ;
            t_load  = 1'b1;
            t_val   = CNT_W'(RD_CYC - 1);
          end else if (bus_quiet) begin
            state_d = ST_WSETUP;
            t_load  = 1'b1;
            t_val   = CNT_W'(SU_CYC - 1);
          end else begin
            state_d = ST_TURN;
          end
        end
      end
      ST_TURN: begin
        if (bus_quiet) begin
          state_d = ST_WSETUP;
          t_load  = 1'b1;
          t_val   = CNT_W'(SU_CYC - 1);
        end
      end
      ST_READ: begin
        if (t_expired) begin
          state_d = ST_IDLE;
          rd_done = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (t_expired) begin
          state_d = ST_WPULSE;
          t_load  = 1'b1;
          t_val   = CNT_W'(WP_CYC - 1);
          we_fall = 1'b1;
        end
      end
      ST_WPULSE: begin
        if (t_expired) begin
          state_d = ST_WREC;
          t_load  = 1'b1;
          t_val   = CNT_W'(REC_CYC - 1);
          we_rise = 1'b1;
        end
      end
      ST_WREC: begin
        if (t_expired) begin
          state_d = ST_IDLE;
          wr_done = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      ce_act  <= 1'b0;
      oe_act  <= 1'b0;
      we_act  <= 1'b0;
      dq_oe_q <= 1'b0;
    end else begin
      state <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        ce_act  <= 1'b1;
        oe_act  <= !req_write;
      end
      if (rd_done) begin
        ce_act <= 1'b0;
        oe_act <= 1'b0;
      end
      if (we_fall) begin
        we_act  <= 1'b1;
        dq_oe_q <= 1'b1;
      end
      if (we_rise) begin
        we_act <= 1'b0;
      end
      if (wr_done) begin
        ce_act  <= 1'b0;
        dq_oe_q <= 1'b0;
      end
    end
  end

  assign sram_addr   = addr_q;
  assign sram_ce_n   = !ce_act;
  assign sram_ce     = ce_act;
  assign sram_oe_n   = !oe_act;
  assign sram_we_n   = !we_act;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = dq_oe_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int          ADDR_W = 13,
  parameter int unsigned WP_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_ce,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic              accept,
  input logic              we_rise
);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (sram_we_n) begin
      we_low_cnt <= '0;
    end else if (we_low_cnt != 16'hFFFF) begin
      we_low_cnt <= we_low_cnt + 16'd1;
    end
  end

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_ce && sram_we_n && !sram_dq_oe));

  p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_ce && sram_oe_n && sram_dq_oe));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_we_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (32'(we_low_cnt) >= WP_CYC));

  p_we_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise |=> $rose(sram_we_n));

  p_addr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_ce));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_ce    (sram_ce),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe),
  .accept     (accept),
  .we_rise    (we_rise)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] sram_addr;
  logic        sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in = '0;

  always #4 clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_NS(P)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, pcnt);
    end
  endtask

  // smallest cycle count covering a time, found by stepping
  function automatic int span(input int ns);
    int n = 0;
    while (n * P < ns) n++;
    return n;
  endfunction

  int rd_cyc;
  int wp_cyc;

  // behavioural RAM storage and scoreboard image
  logic [7:0] ram_mem [int];
  logic [7:0] ref_mem [int];
  int exp_due[$];
  int exp_dat[$];

  int pcnt = 0;
  int nidx = 0;
  always @(posedge clk) pcnt++;

  // monitor state
  logic [12:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  logic p_sel = 0, p_we_n = 1, p_dq_oe = 0, p_rd_en = 0;
  int t_addr = 0, t_ce_on = 0, t_we_fall = 0, t_data = 0;
  int t_rd_start = 0, t_rd_end = 0, t_dqoe_on = 0;
  bit seen_addr = 0, seen_rd = 0;
  logic sel, rd_en;

  always @(negedge clk) begin
    nidx++;
    sel   = !sram_ce_n && sram_ce;
    rd_en = sel && !sram_oe_n && sram_we_n;
    if (rst_n) begin
      if (sram_addr != p_addr) begin
        chk(!p_sel, "R7 addr changed while selected", 1, 0);
        if (seen_addr) chk((pcnt - t_addr) * P >= 80, "R7 addr hold ns", (pcnt - t_addr) * P, 80);
        t_addr = pcnt;
        seen_addr = 1;
      end
      if (sel && !p_sel) t_ce_on = pcnt;
      if (!sram_oe_n) chk(sel && sram_we_n && !sram_dq_oe, "R2 read strobes", 0, 1);
      if (!sram_we_n) chk(sel && sram_oe_n && sram_dq_oe, "R3 write strobes", 0, 1);
      if (!sram_we_n && p_we_n) t_we_fall = pcnt;
      if (sram_dq_out != p_dq || sram_dq_oe != p_dq_oe) begin
        chk(p_we_n, "R6 data changed at write-enable rise", 0, 1);
        t_data = pcnt;
      end
      if (sram_we_n && !p_we_n) begin
        chk((pcnt - t_we_fall) * P >= 60, "R6 pulse ns", (pcnt - t_we_fall) * P, 60);
        chk(pcnt - t_we_fall == wp_cyc, "R10 pulse cycles", pcnt - t_we_fall, wp_cyc);
        chk((pcnt - t_data) * P >= 40, "R6 data setup ns", (pcnt - t_data) * P, 40);
        chk((pcnt - t_ce_on) * P >= 70, "R6 select setup ns", (pcnt - t_ce_on) * P, 70);
        chk((pcnt - t_addr) * P >= 70, "R6 addr setup ns", (pcnt - t_addr) * P, 70);
        chk(p_dq_oe, "R6 data driven", 0, 1);
        ram_mem[int'(sram_addr)] = p_dq;
      end
      if (rd_en && !p_rd_en) t_rd_start = pcnt;
      if (!rd_en && p_rd_en) begin t_rd_end = pcnt; seen_rd = 1; end
      if (sram_dq_oe && !p_dq_oe) t_dqoe_on = pcnt;
      if (sram_dq_oe) begin
        chk(!rd_en, "R8 contention with RAM read", 1, 0);
        if (seen_rd)
          chk((t_dqoe_on - t_rd_end) * P >= 30, "R8 turnaround ns", (t_dqoe_on - t_rd_end) * P, 30);
      end
      if (req_ready) chk(!sel, "R9 ready while selected", 1, 0);
      // reference model: handshake
      if (req_valid && req_ready) begin
        if (req_write) ref_mem[int'(req_addr)] = req_wdata;
        else begin
          exp_due.push_back(nidx + rd_cyc + 1);
          exp_dat.push_back(ref_mem.exists(int'(req_addr)) ? int'(ref_mem[int'(req_addr)]) : 0);
        end
      end
      // reference model: response, every cycle
      if (exp_due.size() > 0 && exp_due[0] == nidx) begin
        chk(rsp_valid, "R4 response missing", int'(rsp_valid), 1);
        chk(int'(rsp_rdata) == exp_dat[0], "R5 read data", int'(rsp_rdata), exp_dat[0]);
        chk(req_ready, "R9 ready with response", int'(req_ready), 1);
        void'(exp_due.pop_front());
        void'(exp_dat.pop_front());
      end else begin
        chk(!rsp_valid, "R4 unexpected response", int'(rsp_valid), 0);
      end
    end
    // RAM output for the coming edge
    if (rd_en && (pcnt + 1 - t_addr) * P >= 80 && (pcnt + 1 - t_rd_start) * P >= 80)
      sram_dq_in = ram_mem.exists(int'(sram_addr)) ? ram_mem[int'(sram_addr)] : 8'h00;
    else if (rd_en)
      sram_dq_in = ~(ram_mem.exists(int'(sram_addr)) ? ram_mem[int'(sram_addr)] : 8'h00);
    else
      sram_dq_in = 8'h00;
    p_addr = sram_addr; p_dq = sram_dq_out; p_sel = sel; p_we_n = sram_we_n;
    p_dq_oe = sram_dq_oe; p_rd_en = rd_en;
  end

  task automatic issue(input bit w, input int a, input int d);
    req_write = w;
    req_addr  = a[12:0];
    req_wdata = d[7:0];
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", pcnt, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rd_cyc = span(80);
    wp_cyc = span(60);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(sram_ce_n == 1'b1 && sram_ce == 1'b0, "R1 enables", int'(sram_ce), 0);
    chk(sram_oe_n == 1'b1 && sram_we_n == 1'b1, "R1 strobes", int'(sram_we_n), 1);
    chk(sram_dq_oe == 1'b0, "R1 bus", int'(sram_dq_oe), 0);
    chk(rsp_valid == 1'b0, "R1 response", int'(rsp_valid), 0);
    @(posedge clk); #1;
    // R5: writes at the range ends and alternating patterns
    issue(1, 0, 8'h3C);
    issue(1, 8191, 8'hFF);
    issue(1, 13'h1555, 8'hAA);
    issue(1, 13'h0AAA, 8'h55);
    // R4, R9: back-to-back reads
    issue(0, 0, 0);
    issue(0, 8191, 0);
    issue(0, 13'h1555, 0);
    issue(0, 13'h0AAA, 0);
    // R8: read immediately followed by write to the same address, then read
    issue(0, 13'h1555, 0);
    issue(1, 13'h1555, 8'h81);
    issue(0, 13'h1555, 0);
    // R5: overwrite twice, then read the last value
    issue(1, 100, 8'h11);
    issue(1, 100, 8'h22);
    issue(0, 100, 0);
    // R5: never-written address reads zero
    issue(0, 4321, 0);
    // mixed traffic from a bench-side shift register
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], (lfsr[3:1] == 3'd7) ? 8191 : int'(lfsr[3:1]) * 977, int'(lfsr[15:8]));
      if (lfsr[4]) repeat (int'(lfsr[6:5])) @(posedge clk);
    end
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(exp_due.size() == 0, "R4 responses drained", exp_due.size(), 0);
    finish_run();
  end

endmodule